// File: doc/BRIEF.md
# Fractional fixed-point DSP ALU

This block is the arithmetic heart of an audio-style DSP engine. Each cycle it takes one 4-bit opcode and three 32-bit signed operands (A, X, Y). From these it produces a 32-bit result R and a 9-bit condition-code word, both combinationally in the same cycle. The operations are:

- Q31 fractional multiply-accumulate, with saturating and wrapping forms and a negated-product form.
- Integer multiply-accumulate.
- A three-operand add.
- A bitwise mask-and-flip.
- Three compare-and-select operations.
- A linear interpolation.

One opcode passes A through unchanged while it accumulates the Q31 product into an internal accumulator. That accumulator is a register, visible on its own output port. It is updated on the rising clock edge when the opcode is issued.

The block sits after operand fetch and before write-back in a microcoded pipeline. Fetch, register files and sequencing live outside it. Three opcode slots (0xC, 0xD, 0xF) belong to operations implemented elsewhere. For those slots the block returns A and still computes flags.

Top module: `fxp_dsp_alu`

## Requirements
- R1: Opcode 0x0 gives R = A + ((X*Y) >>> 31) and opcode 0x1 gives R = A + ((-(X*Y)) >>> 31). The full 64-bit signed product is formed before the arithmetic shift, and both results are clamped to 0x7FFFFFFF / 0x80000000.
- R2: Opcodes 0x2 and 0x3 compute the same sums as 0x0 and 0x1 but keep only the low 32 bits (two's-complement wrap).
- R3: Opcode 0x4 gives A + X*Y (integer product) clamped to the signed 32-bit range. Opcode 0x5 wraps that sum to 31 bits: R[30:0] = sum[30:0] and R[31] = sum[30].
- R4: Opcode 0x6 gives A + X + Y clamped to the signed 32-bit range.
- R5: Opcode 0x7 gives R = A. When `issue` is high at a rising edge, it also adds (X*Y) >>> 31, sign-extended, to the 48-bit accumulator, which wraps modulo 2^48. No other opcode, and no cycle with `issue` low, changes the accumulator.
- R6: Opcode 0x8 gives R = (A & X) ^ Y. Opcode 0x9 gives R = X when A >= Y (signed), else the bitwise inverse of X.
- R7: Opcode 0xA gives X when A >= Y, else Y. Opcode 0xB gives X when A < Y, else Y. Both comparisons are signed.
- R8: Opcode 0xE gives R = A + ((X*(Y-A)) >>> 31), with Y-A formed at 33 bits, clamped to the signed 32-bit range.
- R9: Opcodes 0xC, 0xD and 0xF give R = A.
- R10: The condition-code bits that describe R are:
  - bit 0 (normalized): R[31] != R[30];
  - bit 2 (minus): R[31];
  - bit 3 (zero): R == 0;
  - bit 8 (nonzero): R != 0.

  Bits 5 to 7 are always 0.
- R11: Bit 4 (saturate) is 1 exactly when opcode 0x0, 0x1, 0x4, 0x6 or 0xE had to clamp its result. It is 0 for every other opcode.
- R12: Bit 1 (borrow) is 1 when the opcode is 0x9, 0xA or 0xB and A < Y (signed). It is 0 otherwise.
- R13: An active-low reset clears the accumulator to 0 at once (asynchronously).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the accumulator updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the accumulator |
| issue | input | 1 | Instruction valid this cycle; gates the accumulator update |
| opcode | input | 4 | Operation select |
| a | input | 32 | Operand A (signed) |
| x | input | 32 | Operand X (signed) |
| y | input | 32 | Operand Y (signed) |
| res | output | 32 | Result R (combinational) |
| cc | output | 9 | Condition-code word (combinational) |
| acc_o | output | 48 | Current accumulator value |

## Verification
Opcode 0x7 does two things in one cycle. It drives R = A, with flags taken from A, on the combinational path. It also updates the accumulator at the following edge. When `issue` drops, the first effect must stay and the second must not happen. A random stream provokes these cases. The stream mixes the product-moving opcode with every other opcode. It includes back-to-back accumulating issues and idle cycles. It draws operands from a pool weighted toward the rails (0x7FFFFFFF, 0x80000000, ±1, 0), so that the largest Q31 products hit the accumulator and the A path together. Each cycle, R and the flags are judged against a behavioural model. The accumulator is judged on the next cycle, against a model total that advances only for issued 0x7 operations.

// File: rtl/dspalu_pkg.sv
package dspalu_pkg;

   typedef enum logic [3:0] {
      OP_MACS   = 4'h0,
      OP_MACNS  = 4'h1,
      OP_MACW   = 4'h2,
      OP_MACNW  = 4'h3,
      OP_IMACS  = 4'h4,
      OP_IMACW  = 4'h5,
      OP_ADD3   = 4'h6,
      OP_MACMV  = 4'h7,
      OP_ANDXOR = 4'h8,
      OP_TSTNEG = 4'h9,
      OP_SELGE  = 4'hA,
      OP_SELLT  = 4'hB,
      OP_RSVC   = 4'hC,
      OP_RSVD   = 4'hD,
      OP_LERP   = 4'hE,
      OP_RSVF   = 4'hF
   } alu_op_e;

   // condition-code word layout
   localparam int CC_W      = 9;
   localparam int CC_NORM   = 0;
   localparam int CC_BORROW = 1;
   localparam int CC_MINUS  = 2;
   localparam int CC_ZERO   = 3;
   localparam int CC_SAT    = 4;
   localparam int CC_NONZ   = 8;

   function automatic logic is_sat_op(input alu_op_e o);
      return o inside {OP_MACS, OP_MACNS, OP_IMACS, OP_ADD3, OP_LERP};
   endfunction

   function automatic logic is_cmp_op(input alu_op_e o);
      return o inside {OP_TSTNEG, OP_SELGE, OP_SELLT};
   endfunction

   function automatic logic is_pass_op(input alu_op_e o);
      return o inside {OP_MACMV, OP_RSVC, OP_RSVD, OP_RSVF};
   endfunction

endpackage

// File: rtl/dspalu_mul.sv
// Signed full-width multiplier: both operands are sign-extended to the
// product width so no bit of the result is lost.
module dspalu_mul #(
   parameter int AW = 32,
   parameter int BW = 33
) (
   input  logic signed [AW-1:0]    a,
   input  logic signed [BW-1:0]    b,
   output logic signed [AW+BW-1:0] p
);
   localparam int PW = AW + BW;

   logic signed [PW-1:0] a_ext;
   logic signed [PW-1:0] b_ext;

   assign a_ext = {{BW{a[AW-1]}}, a};
   assign b_ext = {{AW{b[BW-1]}}, b};
   assign p     = a_ext * b_ext;

endmodule

// File: rtl/dspalu_prod.sv
// Product stage: X*Y for the MAC family and X*(Y-A) for interpolation.
// SHARE_MUL=1 time-shares one (DW x DW+1) array between the two products;
// SHARE_MUL=0 builds two arrays and isolates the interpolation one.
module dspalu_prod #(
   parameter int DW        = 32,
   parameter bit SHARE_MUL = 1'b1
) (
   input  logic                 lerp_sel,
   input  logic [DW-1:0]        a,
   input  logic [DW-1:0]        x,
   input  logic [DW-1:0]        y,
   output logic signed [2*DW-1:0] p_xy,
   output logic signed [2*DW:0]   p_lerp
);
   localparam int DW1 = DW + 1;

   logic signed [DW1-1:0] diff;
   logic signed [DW1-1:0] y_ext;

   // 33-bit difference cannot overflow
   assign diff  = $signed({y[DW-1], y}) - $signed({a[DW-1], a});
   assign y_ext = {y[DW-1], y};

   generate
      if (SHARE_MUL) begin : g_shared
         logic signed [DW1-1:0]  b_sel;
         logic signed [2*DW:0]   prod;

         assign b_sel = lerp_sel ? diff : y_ext;

         dspalu_mul #(.AW(DW), .BW(DW1)) u_mul (
            .a (x),
            .b (b_sel),
            .p (prod)
         );

         assign p_xy   = prod[2*DW-1:0];
         assign p_lerp = prod;
      end else begin : g_split
         logic signed [2*DW-1:0] prod_xy;
         logic signed [2*DW:0]   prod_lp;
         logic signed [DW1-1:0]  diff_iso;

         // operand isolation keeps the second array quiet when unused
         assign diff_iso = lerp_sel ? diff : '0;

         dspalu_mul #(.AW(DW), .BW(DW)) u_mul_xy (
            .a (x),
            .b (y),
            .p (prod_xy)
         );

         dspalu_mul #(.AW(DW), .BW(DW1)) u_mul_lp (
            .a (x),
            .b (diff_iso),
            .p (prod_lp)
         );

         assign p_xy   = prod_xy;
         assign p_lerp = prod_lp;
      end
   endgenerate

endmodule

// File: rtl/dspalu_sat.sv
// Clamp a wide signed value into OUT_W bits; flag when clamping occurred.
module dspalu_sat #(
   parameter int IN_W  = 68,
   parameter int OUT_W = 32
) (
   input  logic signed [IN_W-1:0] din,
   output logic [OUT_W-1:0]       dout,
   output logic                   clamped
);
   localparam int HI_W = IN_W - OUT_W + 1;
   localparam logic [OUT_W-1:0] POS_RAIL = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_RAIL = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (IN_W <= OUT_W) begin : g_bad_width
         $error("dspalu_sat: IN_W must exceed OUT_W");
      end
   endgenerate

   logic [HI_W-1:0] hi_bits;
   logic            fits;

   assign hi_bits = din[IN_W-1:OUT_W-1];
   assign fits    = (&hi_bits) | (~|hi_bits);
   assign clamped = ~fits;

   always_comb begin
      if (fits)
         dout = din[OUT_W-1:0];
      else if (din[IN_W-1])
         dout = NEG_RAIL;
      else
         dout = POS_RAIL;
   end

endmodule

// File: rtl/dspalu_acc.sv
// Hidden accumulator: wraps modulo 2^ACC_W, async active-low clear.
module dspalu_acc #(
   parameter int ACC_W = 48,
   parameter int QW    = 34
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [QW-1:0] q,
   output logic [ACC_W-1:0]     acc
);
   generate
      if (ACC_W < QW) begin : g_bad_width
         $error("dspalu_acc: ACC_W must be at least QW");
      end
   endgenerate

   logic [ACC_W-1:0] q_ext;

   assign q_ext = {{(ACC_W-QW){q[QW-1]}}, q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (en)
         acc <= acc + q_ext;
   end

endmodule

// File: rtl/dspalu_ccgen.sv
// Condition-code word builder.
module dspalu_ccgen
   import dspalu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0]   res,
   input  logic            sat_hit,
   input  logic            borrow,
   output logic [CC_W-1:0] cc
);
   always_comb begin
      cc            = '0;
      cc[CC_NORM]   = res[DW-1] ^ res[DW-2];
      cc[CC_BORROW] = borrow;
      cc[CC_MINUS]  = res[DW-1];
      cc[CC_ZERO]   = ~|res;
      cc[CC_SAT]    = sat_hit;
      cc[CC_NONZ]   = |res;
   end

endmodule

// File: rtl/fxp_dsp_alu.sv
// Fractional fixed-point DSP ALU: combinational result and flags,
// registered product accumulator.
module fxp_dsp_alu
   import dspalu_pkg::*;
#(
   parameter int DW        = 32,
   parameter int ACC_W     = 48,
   parameter bit SHARE_MUL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [3:0]       opcode,
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    x,
   input  logic [DW-1:0]    y,
   output logic [DW-1:0]    res,
   output logic [CC_W-1:0]  cc,
   output logic [ACC_W-1:0] acc_o
);
   localparam int FRAC = DW - 1;      // Q-format fraction bits
   localparam int WW   = 2*DW + 4;    // headroom for every sum
   localparam int QW   = DW + 2;      // shifted product width

   generate
      if (DW < 8) begin : g_bad_dw
         $error("fxp_dsp_alu: DW must be at least 8");
      end
      if (ACC_W < QW) begin : g_bad_acc
         $error("fxp_dsp_alu: ACC_W must be at least DW+2");
      end
   endgenerate

   alu_op_e op_e;
   assign op_e = alu_op_e'(opcode);

   // ---------------- products ----------------
   logic signed [2*DW-1:0] p_xy;
   logic signed [2*DW:0]   p_lerp;

   dspalu_prod #(.DW(DW), .SHARE_MUL(SHARE_MUL)) u_prod (
      .lerp_sel (op_e == OP_LERP),
      .a        (a),
      .x        (x),
      .y        (y),
      .p_xy     (p_xy),
      .p_lerp   (p_lerp)
   );

   // ---------------- wide sums ----------------
   logic signed [WW-1:0] a_w, x_w, y_w, pxy_w, plerp_w;
   logic signed [WW-1:0] q_pos, q_neg, q_lerp;
   logic signed [WW-1:0] mac_pos, mac_neg, imac, add3, lerp;

   assign a_w     = {{(WW-DW){a[DW-1]}}, a};
   assign x_w     = {{(WW-DW){x[DW-1]}}, x};
   assign y_w     = {{(WW-DW){y[DW-1]}}, y};
   assign pxy_w   = {{(WW-2*DW){p_xy[2*DW-1]}}, p_xy};
   assign plerp_w = {{(WW-2*DW-1){p_lerp[2*DW]}}, p_lerp};

   assign q_pos   = pxy_w >>> FRAC;
   assign q_neg   = (-pxy_w) >>> FRAC;
   assign q_lerp  = plerp_w >>> FRAC;

   assign mac_pos = a_w + q_pos;
   assign mac_neg = a_w + q_neg;
   assign imac    = a_w + pxy_w;
   assign add3    = a_w + x_w + y_w;
   assign lerp    = a_w + q_lerp;

   // ---------------- saturation ----------------
   logic signed [WW-1:0] sat_in;
   logic [DW-1:0]        sat_out;
   logic                 sat_clamped;

   always_comb begin
      case (op_e)
         OP_MACS:  sat_in = mac_pos;
         OP_MACNS: sat_in = mac_neg;
         OP_IMACS: sat_in = imac;
         OP_ADD3:  sat_in = add3;
         OP_LERP:  sat_in = lerp;
         default:  sat_in = a_w;
      endcase
   end

   dspalu_sat #(.IN_W(WW), .OUT_W(DW)) u_sat (
      .din     (sat_in),
      .dout    (sat_out),
      .clamped (sat_clamped)
   );

   // ---------------- result select ----------------
   logic a_ge_y;
   assign a_ge_y = $signed(a) >= $signed(y);

   always_comb begin
      case (op_e)
         OP_MACS, OP_MACNS, OP_IMACS, OP_ADD3, OP_LERP:
                    res = sat_out;
         OP_MACW:   res = mac_pos[DW-1:0];
         OP_MACNW:  res = mac_neg[DW-1:0];
         OP_IMACW:  res = {imac[DW-2], imac[DW-2:0]};
         OP_ANDXOR: res = (a & x) ^ y;
         OP_TSTNEG: res = a_ge_y ? x : ~x;
         OP_SELGE:  res = a_ge_y ? x : y;
         OP_SELLT:  res = a_ge_y ? y : x;
         default:   res = a;
      endcase
   end

   // ---------------- flags ----------------
   dspalu_ccgen #(.DW(DW)) u_cc (
      .res     (res),
      .sat_hit (sat_clamped & is_sat_op(op_e)),
      .borrow  (is_cmp_op(op_e) & ~a_ge_y),
      .cc      (cc)
   );

   // ---------------- accumulator ----------------
   dspalu_acc #(.ACC_W(ACC_W), .QW(QW)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (issue & (op_e == OP_MACMV)),
      .q     (q_pos[QW-1:0]),
      .acc   (acc_o)
   );

endmodule

// File: rtl/dspalu_chk.sv
// Property checker, attached to the top by bind.
module dspalu_chk
   import dspalu_pkg::*;
#(
   parameter int DW    = 32,
   parameter int ACC_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue,
   input logic [3:0]       opcode,
   input logic [DW-1:0]    a,
   input logic [DW-1:0]    x,
   input logic [DW-1:0]    y,
   input logic [DW-1:0]    res,
   input logic [CC_W-1:0]  cc,
   input logic [ACC_W-1:0] acc_o
);
   localparam logic [DW-1:0] POS_RAIL = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_RAIL = {1'b1, {(DW-1){1'b0}}};

   alu_op_e op_c;
   assign op_c = alu_op_e'(opcode);

   logic signed [2*DW-1:0] prod_c;
   logic [ACC_W-1:0]       step_c;
   logic                   moving;

   assign prod_c = $signed({{DW{x[DW-1]}}, x}) * $signed({{DW{y[DW-1]}}, y});
   assign step_c = ACC_W'(prod_c >>> (DW-1));
   assign moving = issue && (op_c == OP_MACMV);

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !moving |=> $stable(acc_o)); // R5

   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      moving |=> acc_o == $past(acc_o) + $past(step_c)); // R5

   AST_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
      is_pass_op(op_c) |-> res == a); // R9

   AST_SELECT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (op_c == OP_SELGE || op_c == OP_SELLT) |-> (res == x || res == y)); // R7

   AST_SAT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      cc[CC_SAT] |-> (res == POS_RAIL || res == NEG_RAIL)); // R11

   AST_SAT_OPS: assert property (@(posedge clk) disable iff (!rst_n)
      cc[CC_SAT] |-> is_sat_op(op_c)); // R11

   AST_BORROW_OPS: assert property (@(posedge clk) disable iff (!rst_n)
      cc[CC_BORROW] |-> is_cmp_op(op_c)); // R12

   AST_ZERO_XOR_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cc[CC_ZERO], cc[CC_NONZ]}) == 1); // R10

   AST_MINUS_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      cc[CC_MINUS] |-> cc[CC_NONZ]); // R10

   AST_NORM_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      cc[CC_NORM] |-> cc[CC_NONZ]); // R10

   AST_CC_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
      cc[7:5] == 3'b000); // R10

endmodule

bind fxp_dsp_alu dspalu_chk #(.DW(DW), .ACC_W(ACC_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .issue  (issue),
   .opcode (opcode),
   .a      (a),
   .x      (x),
   .y      (y),
   .res    (res),
   .cc     (cc),
   .acc_o  (acc_o)
);

// File: tb/fxp_dsp_alu_bench.sv
`timescale 1ns/1ps
module fxp_dsp_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [3:0]  opcode = 4'h0;
   logic [31:0] a = '0, x = '0, y = '0;
   logic [31:0] res;
   logic [8:0]  cc;
   logic [47:0] acc_o;

   int n_vec  = 0;
   int n_fail = 0;

   logic [47:0] acc_m = '0;   // model accumulator

   always #2 clk = ~clk;      // 250 MHz

   fxp_dsp_alu u_fxp_dsp_alu (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue  (issue),
      .opcode (opcode),
      .a      (a),
      .x      (x),
      .y      (y),
      .res    (res),
      .cc     (cc),
      .acc_o  (acc_o)
   );

   function automatic logic signed [127:0] sx(input logic [31:0] v);
      return {{96{v[31]}}, v};
   endfunction

   // requirement owning each opcode's result
   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'h0, 4'h1: return "R1";
         4'h2, 4'h3: return "R2";
         4'h4, 4'h5: return "R3";
         4'h6:       return "R4";
         4'h7:       return "R5";
         4'h8, 4'h9: return "R6";
         4'hA, 4'hB: return "R7";
         4'hE:       return "R8";
         default:    return "R9";
      endcase
   endfunction

   // behavioural reference of one operation
   task automatic model(input logic [3:0] op, input logic [31:0] av, xv, yv,
                        output logic [31:0] r, output logic [8:0] c,
                        output logic signed [127:0] step);
      logic signed [127:0] A, X, Y, w;
      bit clampable, clamped, lt;
      A = sx(av); X = sx(xv); Y = sx(yv);
      step = (X * Y) >>> 31;
      lt = (A < Y);
      clampable = 0; clamped = 0; w = 0; r = av;
      case (op)
         4'h0: begin w = A + ((X * Y) >>> 31);    clampable = 1; end
         4'h1: begin w = A + ((-(X * Y)) >>> 31); clampable = 1; end
         4'h2: begin w = A + ((X * Y) >>> 31);    r = w[31:0]; end
         4'h3: begin w = A + ((-(X * Y)) >>> 31); r = w[31:0]; end
         4'h4: begin w = A + X * Y;               clampable = 1; end
         4'h5: begin w = A + X * Y;               r = {w[30], w[30:0]}; end
         4'h6: begin w = A + X + Y;               clampable = 1; end
         4'h8: r = (av & xv) ^ yv;
         4'h9: r = lt ? ~xv : xv;
         4'hA: r = lt ? yv : xv;
         4'hB: r = lt ? xv : yv;
         4'hE: begin w = A + ((X * (Y - A)) >>> 31); clampable = 1; end
         default: r = av;
      endcase
      if (clampable) begin
         if (w > 128'sd2147483647) begin r = 32'h7FFFFFFF; clamped = 1; end
         else if (w < -128'sd2147483648) begin r = 32'h80000000; clamped = 1; end
         else r = w[31:0];
      end
      c = '0;
      c[0] = r[31] ^ r[30];
      c[1] = (op inside {4'h9, 4'hA, 4'hB}) && lt;
      c[2] = r[31];
      c[3] = (r == 0);
      c[4] = clamped;
      c[8] = (r != 0);
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] av, xv, yv,
                        input logic iss);
      logic [31:0] r_exp;
      logic [8:0]  c_exp;
      logic signed [127:0] step;
      @(negedge clk);
      opcode = op; a = av; x = xv; y = yv; issue = iss;
      #1;
      model(op, av, xv, yv, r_exp, c_exp, step);
      n_vec++;
      if (res !== r_exp || cc !== c_exp || acc_o !== acc_m) begin
         n_fail++;
         if (res !== r_exp)
            $display("FAIL %s op=%h a=%h x=%h y=%h res actual=%h expected=%h",
                     req_of(op), op, av, xv, yv, res, r_exp);
         if (cc[4] !== c_exp[4])
            $display("FAIL R11 op=%h cc actual=%h expected=%h", op, cc, c_exp);
         else if (cc[1] !== c_exp[1])
            $display("FAIL R12 op=%h cc actual=%h expected=%h", op, cc, c_exp);
         else if (cc !== c_exp)
            $display("FAIL R10 op=%h cc actual=%h expected=%h", op, cc, c_exp);
         if (acc_o !== acc_m)
            $display("FAIL R5 acc actual=%h expected=%h", acc_o, acc_m);
      end
      // accumulator advances at the coming rising edge
      if (iss && op == 4'h7) acc_m = acc_m + step[47:0];
   endtask

   task automatic check_reset();
      @(negedge clk);
      issue = 1'b0;
      rst_n = 1'b0;
      #1;
      n_vec++;
      acc_m = '0;
      if (acc_o !== 48'h0) begin
         n_fail++;
         $display("FAIL R13 acc actual=%h expected=%h", acc_o, 48'h0);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [31:0] pick();
      case ($urandom % 10)
         0: return 32'h7FFFFFFF;
         1: return 32'h80000000;
         2: return 32'h00000000;
         3: return 32'h00000001;
         4: return 32'hFFFFFFFF;
         5: return 32'h40000000;
         6: return 32'hC0000000;
         default: return $urandom;
      endcase
   endfunction

   // watchdog: an expired run counts as a failure
   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #1;
      n_vec++;                                   // R13 at power-up
      if (acc_o !== 48'h0) begin
         n_fail++;
         $display("FAIL R13 acc actual=%h expected=%h", acc_o, 48'h0);
      end
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // directed corners
      apply(4'h0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R1 R11 clamp high
      apply(4'h1, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R1 clamp low
      apply(4'h0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b1); // R1 -1*-1 edge
      apply(4'h2, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R2 wrap
      apply(4'h3, 32'h00000000, 32'h00000001, 32'h00000001, 1'b1); // R2 rounding of negated
      apply(4'h4, 32'h00000001, 32'h00010000, 32'h00010000, 1'b1); // R3 clamp
      apply(4'h5, 32'h3FFFFFFF, 32'h00000001, 32'h00000001, 1'b1); // R3 31-bit wrap
      apply(4'h6, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1); // R4 clamp
      apply(4'h6, 32'h80000000, 32'hFFFFFFFF, 32'h00000001, 1'b1); // R4 no clamp
      apply(4'h7, 32'h12345678, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R5 accumulate
      apply(4'h7, 32'h00000000, 32'h80000000, 32'h80000000, 1'b1); // R5 back-to-back
      apply(4'h7, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b0); // R5 not issued
      apply(4'h0, 32'h00000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R5 other op ignored
      apply(4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0F0F0F0F, 1'b1); // R6 and-xor
      apply(4'h9, 32'hFFFFFFFF, 32'h12345678, 32'h00000000, 1'b1); // R6 R12 A<Y
      apply(4'h9, 32'h00000005, 32'h12345678, 32'h00000005, 1'b1); // R6 A==Y
      apply(4'hA, 32'h80000000, 32'h00000011, 32'h7FFFFFFF, 1'b1); // R7 R12
      apply(4'hB, 32'h80000000, 32'h00000011, 32'h7FFFFFFF, 1'b1); // R7
      apply(4'hB, 32'h00000003, 32'h00000011, 32'h00000003, 1'b1); // R7 equal
      apply(4'hE, 32'h80000000, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1); // R8 full span
      apply(4'hE, 32'h7FFFFFFF, 32'h80000000, 32'h80000000, 1'b1); // R8 R11 clamp
      apply(4'hC, 32'h00000000, 32'h1, 32'h2, 1'b1);               // R9 R10 zero
      apply(4'hD, 32'h40000000, 32'h1, 32'h2, 1'b1);               // R9 R10 norm
      apply(4'hF, 32'h80000000, 32'h1, 32'h2, 1'b1);               // R9 R10 minus

      // random stream with a mid-run reset
      for (int i = 0; i < 3000; i++) begin
         if (i == 1500) check_reset();                            // R13
         apply(($urandom % 3 == 0) ? 4'h7 : 4'($urandom),
               pick(), pick(), pick(), ($urandom % 4) != 0);
      end

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule